// File: doc/BRIEF.md
# Memory Protection Region Register File

This block holds the configuration of a set of memory protection regions and exposes it through a word-addressed register window. Software picks a region through a region-number register, or through a valid bit in the base-address write itself, and then programs that region's base address, size/enable half-word and access-control half-word. Every accepted write that changes protection state gives a single-cycle invalidate pulse, so downstream lookup caches can drop stale translations. The stored fields of every region appear on flat output buses for the address-matching datapath, which is not part of this block.

The region count is a parameter and may be at most 16, because the region selector is four bits wide. The base and attribute registers each answer at four offsets spaced 8 bytes apart, and all four behave the same way. Reads are combinational on the offset. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `mpr_regfile`

## Requirements
- R1: After reset, the control register, the region number and the base, size and access fields of every region are zero, and `inval` and `cfg_warn` are low.
- R2: A read of offset 0xD90 returns NUM_REGIONS shifted left by 8. A write there changes nothing and does not pulse `inval`.
- R3: The control register at 0xD94 keeps only bit 0 (enable), bit 1 (fault-handler enable) and bit 2 (default-map enable). Its other bits read as zero, and every write to it is accepted.
- R4: A control write whose bits 1:0 equal 2'b10 pulses `cfg_warn` high for the one cycle after the write edge. Any other control write leaves `cfg_warn` low.
- R5: A write to the region-number register at 0xD98 takes effect only if the full 32-bit value is below NUM_REGIONS. Otherwise it is ignored. Writes to this register never pulse `inval`.
- R6: A base write with bit 4 clear stores the data with bits 4:0 cleared into the current region. A base read returns the stored base ORed with the current region number in bits 3:0.
- R7: A base write with bit 4 set selects the region given by bits 3:0 and also loads that number into the region-number register. If that number is not below NUM_REGIONS, the whole write is dropped: no field changes, the region number is unchanged and `inval` stays low.
- R8: An attribute write stores data[15:0] & 0xFF3F as size/enable and data[31:16] & 0x173F as access control in the current region. A read returns {access, size}.
- R9: The base register answers at 0xD9C, 0xDA4, 0xDAC and 0xDB4, and the attribute register answers at 0xDA0, 0xDA8, 0xDB0 and 0xDB8. All aliases of a register behave the same.
- R10: `inval` is high for exactly the one cycle after each accepted control, base or attribute write. Writes on back-to-back cycles give back-to-back pulses.
- R11: Offsets outside the window described above read as zero. Writes to them change nothing and do not pulse `inval`.
- R12: Region i's base bits 31:5, size half-word and access half-word appear on `rgn_base`, `rgn_size` and `rgn_access` at slice i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the offset on `addr` |
| addr | input | 12 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| prot_ctrl | output | 3 | Control bits: default-map enable, fault-handler enable, enable |
| cfg_warn | output | 1 | One-cycle flag: fault-handler enable written without enable |
| inval | output | 1 | One-cycle invalidate pulse after an accepted write |
| rgn_base | output | NUM_REGIONS*27 | Per-region base address bits 31:5 |
| rgn_size | output | NUM_REGIONS*16 | Per-region masked size/enable half-word |
| rgn_access | output | NUM_REGIONS*16 | Per-region masked access-control half-word |

## Verification
The assertions check on every cycle that the type value is constant, that reserved control and attribute bits read as zero and that the region number never reads out of range. They also check that control writes always invalidate, that writes to the region number or type register and dropped base writes never invalidate, and that the warning flag follows its condition. Only the directed scenarios can show what is actually stored. This covers the masking results, the region selection through the valid bit with its side effect on the region number, the base readback that merges in the region number, the fact that a rejected write leaves state untouched, and the equivalence of the aliases.

// File: rtl/mpr_pkg.sv
// Package: offsets, masks and widths shared by the protection region
// register file and its checker. Assumes a 12-bit byte offset window.
package mpr_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int SEL_W       = 4;
    localparam int BASE_LSB    = 5;
    localparam int BASE_W      = DATA_W - BASE_LSB;
    localparam int HALF_W      = 16;
    localparam int CTRL_W      = 3;
    localparam int NUM_ALIAS   = 4;
    localparam int ALIAS_STEP  = 8;
    localparam int VALID_BIT   = 4;

    localparam logic [ADDR_W-1:0] OFF_TYPE = 12'hD90;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'hD94;
    localparam logic [ADDR_W-1:0] OFF_RNR  = 12'hD98;
    localparam logic [ADDR_W-1:0] OFF_BASE = 12'hD9C;
    localparam logic [ADDR_W-1:0] OFF_ATTR = 12'hDA0;

    localparam logic [HALF_W-1:0] SIZE_MASK   = 16'hFF3F;
    localparam logic [HALF_W-1:0] ACCESS_MASK = 16'h173F;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_FH_BIT  = 1;
    localparam int CTRL_DEF_BIT = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TYPE,
        ACC_CTRL,
        ACC_RNR,
        ACC_BASE,
        ACC_ATTR
    } acc_kind_e;
endpackage

// File: rtl/mpr_decode.sv
// Offset decoder: classifies the byte offset into a register kind.
// Assumes exact word offsets; any other offset is ACC_NONE.
module mpr_decode
    import mpr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);
    logic [NUM_ALIAS-1:0] base_hit;
    logic [NUM_ALIAS-1:0] attr_hit;

    // One comparator per alias of the base and attribute registers.
    for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
        localparam logic [ADDR_W-1:0] BASE_K = ADDR_W'(int'(OFF_BASE) + k * ALIAS_STEP);
        localparam logic [ADDR_W-1:0] ATTR_K = ADDR_W'(int'(OFF_ATTR) + k * ALIAS_STEP);
        assign base_hit[k] = (addr == BASE_K);
        assign attr_hit[k] = (addr == ATTR_K);
    end

    // Priority-free classification; the hits are mutually exclusive.
    always_comb begin
        kind = ACC_NONE;
        if (addr == OFF_TYPE)  kind = ACC_TYPE;
        if (addr == OFF_CTRL)  kind = ACC_CTRL;
        if (addr == OFF_RNR)   kind = ACC_RNR;
        if (|base_hit)         kind = ACC_BASE;
        if (|attr_hit)         kind = ACC_ATTR;
    end
endmodule

// File: rtl/mpr_ctrl_regs.sv
// Control, region-number, warning and invalidate registers.
// Assumes the caller has already qualified every write strobe.
module mpr_ctrl_regs
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              rnr_we,
    input  logic [SEL_W-1:0]  rnr_wdata,
    input  logic              accept,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [SEL_W-1:0]  rnr_q,
    output logic              warn_q,
    output logic              inval_q
);
    logic warn_cond;

    // Fault-handler enable requested while the enable bit is clear.
    assign warn_cond = ctrl_wdata[CTRL_FH_BIT] & ~ctrl_wdata[CTRL_EN_BIT];

    // Control register holds only its three defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Region number, loaded by its own register or by a valid base write.
    always_ff @(posedge clk) begin
        if (!rst_n)      rnr_q <= '0;
        else if (rnr_we) rnr_q <= rnr_wdata;
    end

    // Single-cycle flags following each qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q  <= 1'b0;
            inval_q <= 1'b0;
        end else begin
            warn_q  <= ctrl_we & warn_cond;
            inval_q <= accept;
        end
    end
endmodule

// File: rtl/mpr_region_bank.sv
// Storage for the per-region base, size and access fields, with a read
// port selected by index. Assumes write strobes are already range checked;
// an out-of-range read index returns zero.
module mpr_region_bank
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          base_we,
    input  logic                          attr_we,
    input  logic [SEL_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [SEL_W-1:0]              rd_idx,
    output logic [BASE_W-1:0]             rd_base,
    output logic [HALF_W-1:0]             rd_size,
    output logic [HALF_W-1:0]             rd_access,
    output logic [NUM_REGIONS*BASE_W-1:0] base_flat,
    output logic [NUM_REGIONS*HALF_W-1:0] size_flat,
    output logic [NUM_REGIONS*HALF_W-1:0] access_flat
);
    logic [BASE_W-1:0] base_r   [NUM_REGIONS];
    logic [HALF_W-1:0] size_r   [NUM_REGIONS];
    logic [HALF_W-1:0] access_r [NUM_REGIONS];

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);

        // Base field of region i, low five bits discarded.
        always_ff @(posedge clk) begin
            if (!rst_n)                          base_r[i] <= '0;
            else if (base_we && wr_idx == IDX)   base_r[i] <= wdata[DATA_W-1:BASE_LSB];
        end

        // Size and access halves of region i, each under its own mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_r[i]   <= '0;
                access_r[i] <= '0;
            end else if (attr_we && wr_idx == IDX) begin
                size_r[i]   <= wdata[HALF_W-1:0] & SIZE_MASK;
                access_r[i] <= wdata[DATA_W-1:HALF_W] & ACCESS_MASK;
            end
        end

        assign base_flat[i*BASE_W +: BASE_W]   = base_r[i];
        assign size_flat[i*HALF_W +: HALF_W]   = size_r[i];
        assign access_flat[i*HALF_W +: HALF_W] = access_r[i];
    end

    // Read selection by comparison, so no index runs past the array.
    always_comb begin
        rd_base   = '0;
        rd_size   = '0;
        rd_access = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (rd_idx == SEL_W'(i)) begin
                rd_base   = base_r[i];
                rd_size   = size_r[i];
                rd_access = access_r[i];
            end
        end
    end
endmodule

// File: rtl/mpr_regfile.sv
// Top of the protection region register file: decodes the offset,
// qualifies writes against the region count, drives the read mux and
// exports all region fields. Assumes 1 <= NUM_REGIONS <= 16.
module mpr_regfile
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [CTRL_W-1:0]             prot_ctrl,
    output logic                          cfg_warn,
    output logic                          inval,
    output logic [NUM_REGIONS*BASE_W-1:0] rgn_base,
    output logic [NUM_REGIONS*HALF_W-1:0] rgn_size,
    output logic [NUM_REGIONS*HALF_W-1:0] rgn_access
);
    localparam logic [SEL_W:0]    COUNT_W1  = (SEL_W+1)'(NUM_REGIONS);
    localparam logic [DATA_W-1:0] COUNT_32  = DATA_W'(NUM_REGIONS);
    localparam logic [DATA_W-1:0] TYPE_WORD = COUNT_32 << 8;

    acc_kind_e         kind;
    logic [SEL_W-1:0]  rnr;
    logic [SEL_W-1:0]  tgt_idx;
    logic              tgt_ok;
    logic              rnr_ok;
    logic              base_sel;
    logic              ctrl_we;
    logic              base_we;
    logic              attr_we;
    logic              rnr_direct_we;
    logic              rnr_we;
    logic [SEL_W-1:0]  rnr_wdata;
    logic              accept;
    logic [BASE_W-1:0] rd_base;
    logic [HALF_W-1:0] rd_size;
    logic [HALF_W-1:0] rd_access;

    mpr_decode u_decode (
        .addr (addr),
        .kind (kind)
    );

    // Write qualification: pick the target region and check its range.
    always_comb begin
        base_sel      = (kind == ACC_BASE) && wdata[VALID_BIT];
        tgt_idx       = base_sel ? wdata[SEL_W-1:0] : rnr;
        tgt_ok        = {1'b0, tgt_idx} < COUNT_W1;
        ctrl_we       = wr_en && (kind == ACC_CTRL);
        base_we       = wr_en && (kind == ACC_BASE) && tgt_ok;
        attr_we       = wr_en && (kind == ACC_ATTR) && tgt_ok;
        rnr_direct_we = wr_en && (kind == ACC_RNR) && (wdata < COUNT_32);
        rnr_we        = rnr_direct_we || (base_we && base_sel);
        rnr_wdata     = wdata[SEL_W-1:0];
        accept        = ctrl_we || base_we || attr_we;
    end

    mpr_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wdata[CTRL_W-1:0]),
        .rnr_we     (rnr_we),
        .rnr_wdata  (rnr_wdata),
        .accept     (accept),
        .ctrl_q     (prot_ctrl),
        .rnr_q      (rnr),
        .warn_q     (cfg_warn),
        .inval_q    (inval)
    );

    mpr_region_bank #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_we     (base_we),
        .attr_we     (attr_we),
        .wr_idx      (tgt_idx),
        .wdata       (wdata),
        .rd_idx      (rnr),
        .rd_base     (rd_base),
        .rd_size     (rd_size),
        .rd_access   (rd_access),
        .base_flat   (rgn_base),
        .size_flat   (rgn_size),
        .access_flat (rgn_access)
    );

    assign rnr_ok = {1'b0, rnr} < COUNT_W1;

    // Read mux; region registers read zero while the region number is out of range.
    always_comb begin
        rdata = '0;
        case (kind)
            ACC_TYPE: rdata = TYPE_WORD;
            ACC_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, prot_ctrl};
            ACC_RNR:  rdata = {{(DATA_W-SEL_W){1'b0}}, rnr};
            ACC_BASE: if (rnr_ok) rdata = {rd_base, {(BASE_LSB-SEL_W){1'b0}}, rnr};
            ACC_ATTR: if (rnr_ok) rdata = {rd_access, rd_size};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mpr_regfile_chk.sv
// Checker for mpr_regfile, observing only its ports; bound below.
module mpr_regfile_chk
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              cfg_warn,
    input logic              inval
);
    localparam logic [DATA_W-1:0] COUNT_32 = DATA_W'(NUM_REGIONS);
    localparam logic [DATA_W-1:0] ATTR_RSV = ~{ACCESS_MASK, SIZE_MASK};

    logic is_base;
    logic is_attr;

    // Independent alias match for the base and attribute windows.
    always_comb begin
        is_base = 1'b0;
        is_attr = 1'b0;
        for (int k = 0; k < NUM_ALIAS; k++) begin
            if (addr == ADDR_W'(int'(OFF_BASE) + k * ALIAS_STEP)) is_base = 1'b1;
            if (addr == ADDR_W'(int'(OFF_ATTR) + k * ALIAS_STEP)) is_attr = 1'b1;
        end
    end

    a_r2_type_value: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_TYPE) |-> (rdata == (COUNT_32 << 8)));

    a_r2_type_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_TYPE) |=> !inval);

    a_r3_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_CTRL) |-> (rdata[DATA_W-1:CTRL_W] == '0));

    a_r10_ctrl_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL) |=> inval);

    a_r4_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL && wdata[1:0] == 2'b10) |=> cfg_warn);

    a_r4_warn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_CTRL && wdata[1:0] == 2'b10) |=> !cfg_warn);

    a_r5_rnr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_RNR) |-> (rdata < COUNT_32));

    a_r5_rnr_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_RNR) |=> !inval);

    a_r7_drop_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_base && wdata[VALID_BIT] && (DATA_W'(wdata[SEL_W-1:0]) >= COUNT_32)) |=> !inval);

    a_r6_base_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
        is_base |-> (rdata[VALID_BIT] == 1'b0));

    a_r8_attr_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        is_attr |-> ((rdata & ATTR_RSV) == '0));
endmodule

bind mpr_regfile mpr_regfile_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .cfg_warn (cfg_warn),
    .inval    (inval)
);

// File: tb/mpr_regfile_bench.sv
// Directed bench for mpr_regfile: one task per scenario.
module mpr_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int BW = 27;
    localparam int HW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [11:0]       addr = 12'h000;
    logic [31:0]       wdata = 32'h0;
    logic [31:0]       rdata;
    logic [2:0]        prot_ctrl;
    logic              cfg_warn;
    logic              inval;
    logic [NREG*BW-1:0] rgn_base;
    logic [NREG*HW-1:0] rgn_size;
    logic [NREG*HW-1:0] rgn_access;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpr_regfile #(.NUM_REGIONS(NREG)) u_mpr_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .prot_ctrl  (prot_ctrl),
        .cfg_warn   (cfg_warn),
        .inval      (inval),
        .rgn_base   (rgn_base),
        .rgn_size   (rgn_size),
        .rgn_access (rgn_access)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write: inputs change at a falling edge, taken at the next rising
    // edge; flags are sampled at the falling edge after it.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            output logic pulse, output logic warn);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        pulse = inval;
        warn = cfg_warn;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 inval after reset", {31'b0, inval}, 32'h0);
        chk("R1 warn after reset", {31'b0, cfg_warn}, 32'h0);
        chk("R1 prot_ctrl after reset", {29'b0, prot_ctrl}, 32'h0);
        do_read(12'hD98, v); chk("R1 region number", v, 32'h0);
        do_read(12'hD9C, v); chk("R1 base region 0", v, 32'h0);
        do_read(12'hDA0, v); chk("R1 attr region 0", v, 32'h0);
        chk("R1 all base fields", {31'b0, |rgn_base}, 32'h0);
        chk("R1 all size/access fields", {31'b0, |{rgn_size, rgn_access}}, 32'h0);
    endtask

    task automatic t_type();
        logic [31:0] v; logic p, w;
        do_read(12'hD90, v); chk("R2 type value", v, 32'h0000_0800);
        do_write(12'hD90, 32'hFFFF_FFFF, p, w);
        chk("R2 type write no inval", {31'b0, p}, 32'h0);
        do_read(12'hD90, v); chk("R2 type unchanged", v, 32'h0000_0800);
    endtask

    task automatic t_ctrl();
        logic [31:0] v; logic p, w;
        do_write(12'hD94, 32'hFFFF_FFFF, p, w);
        chk("R10 ctrl write inval", {31'b0, p}, 32'h1);
        chk("R4 no warn with enable set", {31'b0, w}, 32'h0);
        do_read(12'hD94, v); chk("R3 ctrl keeps 3 bits", v, 32'h7);
        chk("R10 inval single cycle", {31'b0, inval}, 32'h0);
        do_write(12'hD94, 32'h0000_0002, p, w);
        chk("R4 warn fault-handler without enable", {31'b0, w}, 32'h1);
        do_read(12'hD94, v); chk("R3 ctrl value 2", v, 32'h2);
        chk("R4 warn single cycle", {31'b0, cfg_warn}, 32'h0);
        do_write(12'hD94, 32'hFFFF_FFF5, p, w);
        chk("R4 no warn for 01", {31'b0, w}, 32'h0);
        chk("R3 prot_ctrl output", {29'b0, prot_ctrl}, 32'h5);
    endtask

    task automatic t_rnr();
        logic [31:0] v; logic p, w;
        do_write(12'hD98, 32'h3, p, w);
        chk("R5 rnr write no inval", {31'b0, p}, 32'h0);
        do_read(12'hD98, v); chk("R5 rnr 3", v, 32'h3);
        do_write(12'hD98, 32'h8, p, w);
        do_read(12'hD98, v); chk("R5 rnr at count ignored", v, 32'h3);
        do_write(12'hD98, 32'h7, p, w);
        do_read(12'hD98, v); chk("R5 rnr last region", v, 32'h7);
        do_write(12'hD98, 32'h0000_0012, p, w);
        do_read(12'hD98, v); chk("R5 full value compared", v, 32'h7);
    endtask

    task automatic t_base();
        logic [31:0] v; logic p, w;
        do_write(12'hD98, 32'h2, p, w);
        do_write(12'hD9C, 32'h1234_56EF, p, w);
        chk("R10 base write inval", {31'b0, p}, 32'h1);
        do_read(12'hD9C, v); chk("R6 base readback with rnr", v, 32'h1234_56E2);
        chk("R12 region 2 base port", {5'b0, rgn_base[2*BW +: BW]}, 32'h1234_56E0 >> 5);
        do_write(12'hDAC, 32'hABCD_0015, p, w);
        chk("R7 valid select inval", {31'b0, p}, 32'h1);
        do_read(12'hD98, v); chk("R7 rnr loaded by base", v, 32'h5);
        do_read(12'hDB4, v); chk("R9 base alias read", v, 32'hABCD_0005);
        chk("R7 region 2 untouched", {5'b0, rgn_base[2*BW +: BW]}, 32'h1234_56E0 >> 5);
        do_write(12'hDB4, 32'h8000_001A, p, w);
        chk("R7 out-of-range drop no inval", {31'b0, p}, 32'h0);
        do_read(12'hD98, v); chk("R7 rnr unchanged on drop", v, 32'h5);
        do_read(12'hDA4, v); chk("R7 base unchanged on drop", v, 32'hABCD_0005);
    endtask

    task automatic t_attr();
        logic [31:0] v; logic p, w;
        do_write(12'hDA0, 32'hFFFF_FFFF, p, w);
        chk("R10 attr write inval", {31'b0, p}, 32'h1);
        do_read(12'hDA0, v); chk("R8 attr masks", v, 32'h173F_FF3F);
        chk("R12 region 5 size port", {16'b0, rgn_size[5*HW +: HW]}, 32'hFF3F);
        chk("R12 region 5 access port", {16'b0, rgn_access[5*HW +: HW]}, 32'h173F);
        do_write(12'hDB8, 32'h1234_5678, p, w);
        do_read(12'hDB0, v); chk("R9 attr alias write/read", v, 32'h1234_5638);
        do_write(12'hDA8, 32'h0, p, w);
        do_read(12'hDA0, v); chk("R9 attr alias clear", v, 32'h0);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        addr = 12'hD94; wdata = 32'h1; wr_en = 1'b1;
        @(negedge clk);
        chk("R10 back-to-back first", {31'b0, inval}, 32'h1);
        addr = 12'hDA0; wdata = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 back-to-back second", {31'b0, inval}, 32'h1);
        @(negedge clk);
        chk("R10 pulse ends", {31'b0, inval}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v; logic p, w;
        do_write(12'hD00, 32'hFFFF_FFFF, p, w);
        chk("R11 unmapped write no inval", {31'b0, p}, 32'h0);
        do_read(12'hD00, v); chk("R11 unmapped read", v, 32'h0);
        do_read(12'hDBC, v); chk("R11 past alias window", v, 32'h0);
        do_write(12'hDA2, 32'hFFFF_FFFF, p, w);
        chk("R11 misaligned write no inval", {31'b0, p}, 32'h0);
        do_read(12'hDA0, v); chk("R11 attr unchanged", v, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_type();
        t_ctrl();
        t_rnr();
        t_base();
        t_attr();
        t_b2b();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule